// File: doc/BRIEF.md
# Reset-Cause Status Register

This block is a byte-wide, read-only status register that sits on a simple peripheral bus. Software reads it to learn why the device last restarted, which operating environment the board selected at startup, and whether the flash memories are busy. Two sticky flags record watchdog resets and software-initiated ISP resets. A three-bit environment code is captured from the board pins while the chip reset is active. Two busy indicators come straight from the flash controller and are shown without delay.

The flags sit in a hard reset domain that only power-on and external reset can clear. They therefore survive the watchdog and software resets they record. The watchdog flag is cleared when software writes a one to bit 6. The ISP flag ignores register writes and clears only on a pulse from the software-clear sequence. When a set event and a clear arrive in the same cycle, the set wins. The watchdog timer, the reset generator and the flash controller are outside this block and appear only as input signals.

Top module: `rst_cause_status`

## Requirements
- R1: After power-on reset, both flags read 0. Bit 7 is the ISP flag and bit 6 is the watchdog flag.
- R2: While `sys_rst_n` is low, bits 2:0 follow `env_pins` at each clock. After `sys_rst_n` goes high they hold the last sampled value, whatever the pins do.
- R3: Bit 3 reads 1 when any of `pmem_busy`, `dmem_erasing` or `dmem_pipe_prog` is 1, and reads 0 otherwise, in the same cycle.
- R4: Bit 4 reads 1 when `dmem_erasing` or `dmem_pipe_prog` is 1, and reads 0 otherwise, in the same cycle.
- R5: A one-cycle `wdt_rst_evt` pulse sets bit 6 at the next clock edge. The bit stays set until it is cleared.
- R6: A write with `wr_data[6]`=1 clears bit 6 at the next edge. A write with `wr_data[6]`=0 leaves bit 6 unchanged.
- R7: A one-cycle `isp_rst_evt` pulse sets bit 7. A one-cycle `isp_clr_evt` pulse clears it. Register writes of any value leave it unchanged.
- R8: Both flags keep their values through a chip reset (`sys_rst_n` low). Both are cleared when `por_n` or `ext_rst_n` goes low.
- R9: When a set event and a clear for the same flag occur in the same cycle, the flag ends up set.
- R10: Bit 5 always reads 0. `rd_data` is 0 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| sys_rst_n | input | 1 | Chip-wide reset from any cause, active low |
| env_pins | input | 3 | Operating environment pins |
| pmem_busy | input | 1 | Program flash busy programming or erasing |
| dmem_erasing | input | 1 | Data flash erasing |
| dmem_pipe_prog | input | 1 | Data flash pipelined programming in progress |
| wdt_rst_evt | input | 1 | Watchdog reset event pulse |
| isp_rst_evt | input | 1 | Software ISP reset event pulse |
| isp_clr_evt | input | 1 | Software-clear sequence pulse |
| rd_en | input | 1 | Bus read strobe |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Status byte, gated by `rd_en` |

## Verification
On every cycle, the assertions check that each set event leaves its flag set, that a watchdog clear write with no competing set leaves bit 6 clear, and that the ISP flag holds its value when neither of its events is present. They also check that the environment code holds steady outside chip reset, and that a read showing data-flash busy also shows flash busy. Other behaviour needs the bench's scenarios. These include flags surviving a chip reset but not an external or power-on reset, the environment code being recaptured across a watchdog-driven chip reset, and writes leaving the ISP flag untouched. The bench also covers the full table of busy-input combinations.

// File: rtl/rst_cause_status.sv
module rst_cause_status (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ext_rst_n,
  input  logic       sys_rst_n,
  input  logic [2:0] env_pins,
  input  logic       pmem_busy,
  input  logic       dmem_erasing,
  input  logic       dmem_pipe_prog,
  input  logic       wdt_rst_evt,
  input  logic       isp_rst_evt,
  input  logic       isp_clr_evt,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);
  localparam int WD_BIT = 6;
  localparam logic [7:0] WD_MASK = 8'(1) << WD_BIT;

  logic       hard_rst_n;
  logic       wd_q, isp_q;
  logic [2:0] env_q;
  logic       wd_clr;
  logic       dflash_busy, flash_busy;

  assign hard_rst_n  = por_n & ext_rst_n;
  assign wd_clr      = wr_en && ((wr_data & WD_MASK) != 8'h00);
  assign dflash_busy = dmem_erasing | dmem_pipe_prog;
  assign flash_busy  = pmem_busy | dflash_busy;

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      wd_q  <= 1'b0;
      isp_q <= 1'b0;
    end else begin
      if (wdt_rst_evt)      wd_q <= 1'b1;
      else if (wd_clr)      wd_q <= 1'b0;
      if (isp_rst_evt)      isp_q <= 1'b1;
      else if (isp_clr_evt) isp_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!sys_rst_n) env_q <= env_pins;
  end

  assign rd_data = rd_en ? {isp_q, wd_q, 1'b0, dflash_busy, flash_busy, env_q} : 8'h00;
endmodule

// File: rtl/rst_cause_status_chk.sv
module rst_cause_status_chk (
  input logic       clk,
  input logic       hrst_n,
  input logic       sys_rst_n,
  input logic       wd_q,
  input logic       isp_q,
  input logic [2:0] env_q,
  input logic       wdt_rst_evt,
  input logic       isp_rst_evt,
  input logic       isp_clr_evt,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       rd_en,
  input logic [7:0] rd_data
);
  // R5
  wd_set_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    wdt_rst_evt |=> wd_q);
  // R7
  isp_set_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    isp_rst_evt |=> isp_q);
  // R6
  wd_clr_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    (wr_en && wr_data[6] && !wdt_rst_evt) |=> !wd_q);
  // R7
  isp_hold_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    (!isp_rst_evt && !isp_clr_evt) |=> $stable(isp_q));
  // R2
  env_hold_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $past(sys_rst_n) |-> $stable(env_q));
  // R3
  busy_nest_chk: assert property (@(posedge clk) disable iff (!hrst_n)
    (rd_en && rd_data[4]) |-> rd_data[3]);
endmodule

bind rst_cause_status rst_cause_status_chk u_chk (
  .clk(clk), .hrst_n(hard_rst_n), .sys_rst_n(sys_rst_n),
  .wd_q(wd_q), .isp_q(isp_q), .env_q(env_q),
  .wdt_rst_evt(wdt_rst_evt), .isp_rst_evt(isp_rst_evt), .isp_clr_evt(isp_clr_evt),
  .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
);

// File: tb/sim_rst_cause_status.sv
module sim_rst_cause_status;
  localparam int CLK_P = 10;

  logic clk = 0;
  logic por_n = 0, ext_rst_n = 1, sys_rst_n = 0;
  logic [2:0] env_pins = 3'b101;
  logic pmem_busy = 0, dmem_erasing = 0, dmem_pipe_prog = 0;
  logic wdt_rst_evt = 0, isp_rst_evt = 0, isp_clr_evt = 0;
  logic rd_en = 1, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rst_cause_status u0 (.*);

  // {pmem_busy, dmem_erasing, dmem_pipe_prog, exp bit4, exp bit3}
  localparam logic [4:0] MIR_VEC [8] = '{
    5'b000_00, 5'b001_11, 5'b010_11, 5'b011_11,
    5'b100_01, 5'b101_11, 5'b110_11, 5'b111_11 };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tick(3);
    por_n = 1; sys_rst_n = 1;
    tick();
    chk("R1", rd_data, 8'h05);
    env_pins = 3'b010;
    tick(2);
    chk("R2", rd_data[2:0], 3'b101);

    for (int i = 0; i < 8; i++) begin
      {pmem_busy, dmem_erasing, dmem_pipe_prog} = MIR_VEC[i][4:2];
      #1;
      chk("R3", {7'd0, rd_data[3]}, {7'd0, MIR_VEC[i][0]});
      chk("R4", {7'd0, rd_data[4]}, {7'd0, MIR_VEC[i][1]});
    end
    {pmem_busy, dmem_erasing, dmem_pipe_prog} = 3'b000;
    tick();

    wdt_rst_evt = 1; sys_rst_n = 0;
    tick();
    wdt_rst_evt = 0;
    tick();
    sys_rst_n = 1;
    tick();
    chk("R5", rd_data, 8'h42);
    chk("R8", {7'd0, rd_data[6]}, 8'h01);
    chk("R2", rd_data[2:0], 3'b010);
    env_pins = 3'b111;
    tick(2);
    chk("R5", rd_data, 8'h42);

    wr_en = 1; wr_data = 8'hBF; tick(); wr_en = 0;
    chk("R6", rd_data[6], 1'b1);

    isp_rst_evt = 1; tick(); isp_rst_evt = 0;
    chk("R7", rd_data, 8'hC2);
    wr_en = 1; wr_data = 8'hFF; tick(); wr_en = 0;
    chk("R6", rd_data, 8'h82);
    chk("R7", rd_data[7], 1'b1);
    wr_en = 1; wr_data = 8'h00; tick(); wr_en = 0;
    chk("R7", rd_data[7], 1'b1);
    isp_clr_evt = 1; tick(); isp_clr_evt = 0;
    chk("R7", rd_data, 8'h02);

    wdt_rst_evt = 1; wr_en = 1; wr_data = 8'h40; tick();
    wdt_rst_evt = 0; wr_en = 0;
    chk("R9", rd_data[6], 1'b1);
    isp_rst_evt = 1; isp_clr_evt = 1; tick();
    isp_rst_evt = 0; isp_clr_evt = 0;
    chk("R9", rd_data[7], 1'b1);

    sys_rst_n = 0; tick(2); sys_rst_n = 1; tick();
    chk("R8", rd_data[7:6], 2'b11);
    chk("R2", rd_data[2:0], 3'b111);

    ext_rst_n = 0; sys_rst_n = 0; tick(2); ext_rst_n = 1; sys_rst_n = 1; tick();
    chk("R8", rd_data[7:6], 2'b00);

    wdt_rst_evt = 1; isp_rst_evt = 1; tick(); wdt_rst_evt = 0; isp_rst_evt = 0;
    chk("R8", rd_data[7:6], 2'b11);
    por_n = 0; sys_rst_n = 0; tick(2); por_n = 1; sys_rst_n = 1; tick();
    chk("R1", rd_data[7:6], 2'b00);

    pmem_busy = 1; dmem_erasing = 1;
    wdt_rst_evt = 1; tick(); wdt_rst_evt = 0;
    chk("R10", {7'd0, rd_data[5]}, 8'h00);
    rd_en = 0; #1;
    chk("R10", rd_data, 8'h00);
    rd_en = 1;
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule